// File: doc/BRIEF.md
# Instruction-Boundary Interrupt Arbiter

This block gathers level-sensitive hardware interrupt requests for a small CPU. It decides whether the CPU enters interrupt processing only when the core signals that an instruction has completed. It never acts in the middle of an instruction. At such a boundary it qualifies each request with its own enable bit and with the global interrupt mask from the condition code register. It then picks the winner by fixed priority, where source 0 is the most urgent, and latches the result as a constant vector index that the core uses to choose its vector.

Once a source is latched, the choice is frozen. A later request does not replace it, even one of higher priority, until the core acknowledges service or clears the mask bit. A return-from-interrupt is an ordinary instruction boundary. A request that is still asserted when the return completes is therefore taken again before any background instruction runs.

All pins are plain control and status signals. No data stream crosses the block, so it has no valid/ready handshake.

Top module: `irq_boundary_arbiter`

## Requirements
- R1: Synchronous active-high reset clears the latched flag and the take pulse, and forces the vector index to its idle value.
- R2: Requests are evaluated only in a cycle where `insn_done` is high. With `insn_done` low, no request is latched, whatever its level.
- R3: While `irq_mask` is 1, no request is latched at a boundary. The block stays idle and the next instruction proceeds.
- R4: A source whose bit in `irq_en` is 0 is never selected, even when its request is high.
- R5: Among qualified requests at one boundary, the lowest source index is latched.
- R6: A latch event raises `take_irq` for exactly one clock, in the cycle after the boundary edge. `irq_latched` then stays 1 until it is released.
- R7: While a source is latched, later boundaries and new requests of any priority leave `vec_idx` unchanged and raise no `take_irq`.
- R8: `svc_ack` releases the latch. From the next cycle, `irq_latched` is 0 and `vec_idx` is idle. No new source is latched in the cycle that performs a release.
- R9: A falling edge of `irq_mask` (1 in the previous cycle, 0 now) while a source is latched also releases the latch.
- R10: Requests are level sensitive. A source still asserted after release is latched again at the next boundary with the mask clear, as happens when a return completes.
- R11: `vec_idx` is `VW = $clog2(NUM_SRC+1)` bits wide. Its idle value is all ones (4'hF for the default of 8 sources), which never encodes a real source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_req | input | NUM_SRC | Level request per source, bit i is source i |
| irq_en | input | NUM_SRC | Enable per source |
| irq_mask | input | 1 | Global interrupt mask, 1 blocks |
| insn_done | input | 1 | Instruction-completion strobe |
| svc_ack | input | 1 | Service acknowledge from the core |
| take_irq | output | 1 | One-cycle pulse when a source is latched |
| irq_latched | output | 1 | A source is held |
| vec_idx | output | VW | Latched source index, all ones when idle |

## Verification
The assertions check several rules on every cycle. A take pulse lasts one clock, follows a boundary and an unmasked mask, and comes with the latched flag. The vector index is idle whenever nothing is latched. A held index stays constant until an acknowledge or a mask falling edge, and the priority grant is at most one-hot. The bench scenarios are needed to show which source wins for given request and enable patterns, that a masked or disabled request is ignored, and that a level still held after release is taken again at the following return boundary.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;
  function automatic int vec_width(input int n_src);
    return $clog2(n_src + 1);
  endfunction
endpackage

// File: rtl/irq_qualify.sv
module irq_qualify #(
  parameter int NUM_SRC = 8
) (
  input  logic [NUM_SRC-1:0] req,
  input  logic [NUM_SRC-1:0] en,
  input  logic               mask,
  output logic [NUM_SRC-1:0] qual
);
  always_comb qual = mask ? '0 : (req & en);
endmodule

// File: rtl/irq_prio_enc.sv
module irq_prio_enc #(
  parameter int NUM_SRC = 8,
  parameter int VW      = irq_arb_pkg::vec_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] qual,
  output logic               any,
  output logic [VW-1:0]      win
);
  logic [NUM_SRC-1:0] grant;
  logic [NUM_SRC:0]   seen;

  assign seen[0] = 1'b0;
  for (genvar i = 0; i < NUM_SRC; i++) begin : g_chain
    assign grant[i]  = qual[i] & ~seen[i];
    assign seen[i+1] = seen[i] | qual[i];
  end

  always_comb begin
    win = '0;
    for (int i = 0; i < NUM_SRC; i++)
      if (grant[i]) win = win | VW'(i);
  end
  assign any = seen[NUM_SRC];

  // R5
  grant_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(grant) && (any == (grant != '0)));
endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl #(
  parameter int VW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          insn_done,
  input  logic          mask,
  input  logic          ack,
  input  logic          any,
  input  logic [VW-1:0] win,
  output logic          take,
  output logic          held,
  output logic [VW-1:0] idx
);
  localparam logic [VW-1:0] IDLE = '1;
  logic mask_q;
  logic release_now;

  assign release_now = held && (ack || (mask_q && !mask));

  always_ff @(posedge clk) begin
    if (rst) begin
      take   <= 1'b0;
      held   <= 1'b0;
      idx    <= IDLE;
      mask_q <= 1'b0;
    end else begin
      mask_q <= mask;
      take   <= 1'b0;
      if (release_now) begin
        held <= 1'b0;
        idx  <= IDLE;
      end else if (!held && insn_done && any) begin
        take <= 1'b1;
        held <= 1'b1;
        idx  <= win;
      end
    end
  end

  // R6
  take_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    take |=> !take);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (held && !ack && !(mask_q && !mask)) |=> (held && $stable(idx) && !take));
endmodule

// File: rtl/irq_boundary_arbiter.sv
module irq_boundary_arbiter #(
  parameter int NUM_SRC = 8,
  localparam int VW     = irq_arb_pkg::vec_width(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irq_req,
  input  logic [NUM_SRC-1:0] irq_en,
  input  logic               irq_mask,
  input  logic               insn_done,
  input  logic               svc_ack,
  output logic               take_irq,
  output logic               irq_latched,
  output logic [VW-1:0]      vec_idx
);
  logic [NUM_SRC-1:0] qual;
  logic               any;
  logic [VW-1:0]      win;

  irq_qualify #(.NUM_SRC(NUM_SRC)) u_qual (
    .req(irq_req), .en(irq_en), .mask(irq_mask), .qual(qual));

  irq_prio_enc #(.NUM_SRC(NUM_SRC), .VW(VW)) u_enc (
    .clk(clk), .rst(rst), .qual(qual), .any(any), .win(win));

  irq_latch_ctrl #(.VW(VW)) u_ctl (
    .clk(clk), .rst(rst), .insn_done(insn_done), .mask(irq_mask),
    .ack(svc_ack), .any(any), .win(win),
    .take(take_irq), .held(irq_latched), .idx(vec_idx));

  // R2
  take_at_boundary_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(take_irq) |-> $past(insn_done));
  // R3
  take_unmasked_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(take_irq) |-> !$past(irq_mask));
  // R6
  take_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
    take_irq |-> irq_latched);
  // R11
  idle_vec_chk: assert property (@(posedge clk) disable iff (rst)
    !irq_latched |-> (vec_idx == '1));
  // R8
  ack_release_chk: assert property (@(posedge clk) disable iff (rst)
    (irq_latched && svc_ack) |=> !irq_latched);
endmodule

// File: tb/tb_irq_boundary_arbiter.sv
module tb_irq_boundary_arbiter;
  localparam int N  = 8;
  localparam int VW = 4;

  logic clk = 1'b0;
  logic rst;
  logic [N-1:0] irq_req, irq_en;
  logic irq_mask, insn_done, svc_ack;
  logic take_irq, irq_latched;
  logic [VW-1:0] vec_idx;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles <= cycles + 1;

  irq_boundary_arbiter #(.NUM_SRC(N)) dut (
    .clk(clk), .rst(rst), .irq_req(irq_req), .irq_en(irq_en),
    .irq_mask(irq_mask), .insn_done(insn_done), .svc_ack(svc_ack),
    .take_irq(take_irq), .irq_latched(irq_latched), .vec_idx(vec_idx));

  // {req, en, mask, expect_take, expect_idx}
  localparam int VL = 2*N + 2 + VW;
  localparam logic [VL-1:0] VEC [8] = '{
    {8'h01, 8'hFF, 1'b0, 1'b1, 4'h0},
    {8'h80, 8'hFF, 1'b0, 1'b1, 4'h7},
    {8'hA4, 8'hFF, 1'b0, 1'b1, 4'h2},
    {8'hFF, 8'hFF, 1'b1, 1'b0, 4'hF},
    {8'h0C, 8'h08, 1'b0, 1'b1, 4'h3},
    {8'hF0, 8'h0F, 1'b0, 1'b0, 4'hF},
    {8'h06, 8'hFF, 1'b0, 1'b1, 4'h1},
    {8'h00, 8'hFF, 1'b0, 1'b0, 4'hF}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic [N-1:0] rq, input logic [N-1:0] en,
                      input logic m, input logic d, input logic a);
    irq_req = rq; irq_en = en; irq_mask = m; insn_done = d; svc_ack = a;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic summary;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  initial begin
    wait (cycles > 20000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog actual=%0d expected=<20000", cycles);
    summary();
  end

  initial begin
    rst = 1'b1; irq_req = '0; irq_en = '0; irq_mask = 1'b0;
    insn_done = 1'b0; svc_ack = 1'b0;
    @(negedge clk); step('1, '1, 1'b0, 1'b1, 1'b0);
    // R1 reset state, even with requests present
    chk("R1 latched", irq_latched, 0);
    chk("R1 take", take_irq, 0);
    chk("R1 vec", vec_idx, 4'hF);
    rst = 1'b0;
    step('0, '1, 1'b0, 1'b0, 1'b0);

    // Table: R3 R4 R5 R11
    for (int k = 0; k < 8; k++) begin
      step(VEC[k][VL-1 -: N], VEC[k][VL-N-1 -: N], VEC[k][VW+1], 1'b1, 1'b0);
      chk($sformatf("R5 vec%0d take", k), take_irq, VEC[k][VW]);
      chk($sformatf("R4 vec%0d idx", k), vec_idx, VEC[k][VW-1:0]);
      step('0, '1, 1'b0, 1'b0, 1'b1);
      chk($sformatf("R8 vec%0d clear", k), {irq_latched, vec_idx}, {1'b0, 4'hF});
    end

    // R2 no boundary, no latch
    step(8'h10, '1, 1'b0, 1'b0, 1'b0);
    chk("R2 no boundary", irq_latched, 0);
    // R6 pulse then hold
    step(8'h08, '1, 1'b0, 1'b1, 1'b0);
    chk("R6 pulse", {take_irq, irq_latched, vec_idx}, {1'b1, 1'b1, 4'h3});
    step(8'h08, '1, 1'b0, 1'b0, 1'b0);
    chk("R6 one cycle", {take_irq, irq_latched}, {1'b0, 1'b1});
    // R7 higher priority at later boundary does not pre-empt
    step(8'h09, '1, 1'b0, 1'b1, 1'b0);
    chk("R7 frozen", {take_irq, irq_latched, vec_idx}, {1'b0, 1'b1, 4'h3});
    // R8 ack with boundary in same cycle: release only
    step(8'h01, '1, 1'b0, 1'b1, 1'b1);
    chk("R8 release", {take_irq, irq_latched, vec_idx}, {1'b0, 1'b0, 4'hF});
    // R10 held level retaken at return boundary
    step(8'h01, '1, 1'b0, 1'b1, 1'b0);
    chk("R10 retake", {take_irq, vec_idx}, {1'b1, 4'h0});
    // R9 mask set then cleared releases
    step(8'h00, '1, 1'b1, 1'b0, 1'b0);
    chk("R9 still held", irq_latched, 1);
    step(8'h00, '1, 1'b0, 1'b0, 1'b0);
    chk("R9 mask fall", {irq_latched, vec_idx}, {1'b0, 4'hF});
    // R3 masked boundary after release
    step(8'h20, '1, 1'b1, 1'b1, 1'b0);
    chk("R3 masked", {take_irq, irq_latched}, {1'b0, 1'b0});
    // R1 reset while latched
    step(8'h20, '1, 1'b0, 1'b1, 1'b0);
    chk("R5 single", vec_idx, 4'h5);
    rst = 1'b1;
    step('0, '1, 1'b0, 1'b0, 1'b0);
    chk("R1 reset held", {irq_latched, vec_idx}, {1'b0, 4'hF});
    rst = 1'b0;
    step('0, '1, 1'b0, 1'b0, 1'b0);
    summary();
  end
endmodule